// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a small nonvolatile serial memory of 2048 bits that answers on a three-wire bus: a select line, a serial clock and a data input, with a data output that is either driven or released. An organization input picks between sixteen-bit words and bytes at run time. A host frames each instruction with a start bit, an opcode and an address, then either clocks data in or clocks data out. The block runs on a fast system clock and samples the serial clock and the select line as plain inputs, detecting the rising edges of the serial clock itself.

Writes, single-word erases, whole-array fills and whole-array erases are self-timed: the host completes the instruction, drops select to launch it, and may then raise select again to watch the data output, which reads low while the cycle runs and high once it is over. A protection latch, cleared at reset, has to be opened by an enable instruction before any programming instruction takes effect. The cell contents are held in ordinary registers; reset sets them to the erased value.

Top module: `uw_eeprom`

## Requirements
- R1: With `org` high the array is 128 words of 16 bits with a 7-bit address; with `org` low it is 256 bytes with an 8-bit address. Word a in the wide mode is made of byte 2a (upper half) and byte 2a+1 (lower half) of the byte view.
- R2: An instruction starts at the first rising serial-clock edge that samples `di` high while select is high; zeros clocked before it are ignored. The next two bits are the opcode (10 read, 01 write, 11 erase, 00 extended), then the address MSB first. For opcode 00 the two top address bits pick: 11 enable programming, 00 disable programming, 10 erase all, 01 fill all.
- R3: On a read, `do_oe` rises on the edge that takes the last address bit and `do_o` shows one 0 bit; each further rising edge presents the next data bit, MSB first.
- R4: If clocking continues after the last bit of a word, the read moves on to the next address with no extra dummy bit, wrapping from the top address to 0 in either organization.
- R5: A write (16 data bits wide, 8 bits byte-wide) is stored only when select falls after the last data bit; a byte-wide write changes one byte and no other.
- R6: After reset programming is disabled; write, erase, erase-all and fill-all then change nothing and start no self-timed cycle, and the disable instruction restores that state.
- R7: An erase sets the addressed word to all ones and leaves its neighbours unchanged.
- R8: Erase-all sets every location to all ones; fill-all writes the given word to every location.
- R9: While a self-timed cycle runs, raising select drives `do_o` low; when the cycle ends `do_o` goes high. Bits clocked in while busy start no instruction.
- R10: Select low at any point abandons a partly received instruction, starts nothing, and releases `do_oe` one clock later.
- R11: After reset `do_oe` is low and every location reads all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select, active high |
| sk | input | 1 | Serial clock, sampled on `clk` |
| di | input | 1 | Serial data in |
| org | input | 1 | 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Serial data out enable (0 = high impedance) |

## Verification
The properties assume that the serial clock and select are slow against the system clock, so each serial-clock level spans several system clocks and only one edge is seen per level, and that `org` does not change while select is high. The bench drives every serial level for at least two system clocks, moves inputs only on the falling edge of `clk`, keeps `org` still for whole instructions, and waits for the ready indication before starting the next programming instruction.

// File: rtl/uw_pkg.sv
package uw_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int N_BYTES  = 256;
    localparam int BADDR_W  = $clog2(N_BYTES);
    localparam int CMD_W    = 2 + BADDR_W;
    localparam int CNT_W    = $clog2(WORD_W) + 1;

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT, S_STAT, S_CMD, S_DATA, S_READ, S_ARMED, S_DONE
    } uw_state_e;

    typedef enum logic [1:0] {
        K_WORD, K_ERASE, K_FILL, K_CLEAR
    } uw_kind_e;

    typedef enum logic [1:0] {
        P_NONE, P_ONE, P_ALL
    } uw_prog_e;

    typedef struct packed {
        uw_state_e          st;
        logic               sk;
        logic [CNT_W-1:0]   cnt;
        logic [CMD_W-1:0]   cmd;
        logic [WORD_W-1:0]  data;
        logic [BADDR_W-1:0] addr;
        uw_kind_e           kind;
        logic               ewen;
        logic               dout;
        logic               oe;
    } uw_regs_t;
endpackage

// File: rtl/uw_busy.sv
module uw_busy #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/uw_store.sv
module uw_store
    import uw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  uw_prog_e           prog,
    input  logic               org,
    input  logic [BADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [BADDR_W-1:0] raddr,
    output logic [WORD_W-1:0]  rword
);
    logic [N_BYTES*BYTE_W-1:0] flat;

    for (genvar i = 0; i < N_BYTES; i++) begin : g_cell
        localparam logic [BADDR_W-1:0] IDX = BADDR_W'(i);
        logic [BYTE_W-1:0] cell_d, cell_q;
        logic              hit;

        always_comb begin
            hit    = 1'b0;
            cell_d = cell_q;
            if (prog == P_ALL) begin
                hit = 1'b1;
            end else if (prog == P_ONE) begin
                hit = org ? (waddr[BADDR_W-2:0] == IDX[BADDR_W-1:1])
                          : (waddr == IDX);
            end
            if (hit) begin
                cell_d = (org && !IDX[0]) ? wdata[WORD_W-1:BYTE_W]
                                          : wdata[BYTE_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '1;
            else        cell_q <= cell_d;
        end

        assign flat[i*BYTE_W +: BYTE_W] = cell_q;
    end

    logic [BADDR_W-1:0] hi_idx, lo_idx;

    always_comb begin
        hi_idx = {raddr[BADDR_W-2:0], 1'b0};
        lo_idx = {raddr[BADDR_W-2:0], 1'b1};
        if (org) begin
            rword = {flat[hi_idx*BYTE_W +: BYTE_W], flat[lo_idx*BYTE_W +: BYTE_W]};
        end else begin
            rword = {{BYTE_W{1'b0}}, flat[raddr*BYTE_W +: BYTE_W]};
        end
    end
endmodule

// File: rtl/uw_ctrl.sv
module uw_ctrl
    import uw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               sk,
    input  logic               di,
    input  logic               org,
    input  logic               busy,
    input  logic [WORD_W-1:0]  rword,
    output logic [BADDR_W-1:0] addr,
    output uw_prog_e           prog,
    output logic [WORD_W-1:0]  wdata,
    output logic               start,
    output logic               ewen,
    output logic               do_o,
    output logic               do_oe
);
    uw_regs_t r_d, r_q;

    logic               rise;
    logic [CNT_W-1:0]   wlen, clen;
    logic [CMD_W-1:0]   cmdv;
    logic [1:0]         opc, sub;
    logic [BADDR_W-1:0] cadr, inc;
    logic [WORD_W-1:0]  datv;

    always_comb begin
        r_d       = r_q;
        r_d.sk    = sk;
        rise      = sk & ~r_q.sk;
        prog      = P_NONE;
        start     = 1'b0;
        wlen      = org ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
        clen      = org ? CNT_W'(CMD_W - 1) : CNT_W'(CMD_W);
        cmdv      = {r_q.cmd[CMD_W-2:0], di};
        datv      = {r_q.data[WORD_W-2:0], di};
        if (org) begin
            opc  = cmdv[CMD_W-2 -: 2];
            cadr = {1'b0, cmdv[BADDR_W-2:0]};
            sub  = cmdv[BADDR_W-2 -: 2];
        end else begin
            opc  = cmdv[CMD_W-1 -: 2];
            cadr = cmdv[BADDR_W-1:0];
            sub  = cmdv[BADDR_W-1 -: 2];
        end
        inc = org ? {1'b0, r_q.addr[BADDR_W-2:0] + 1'b1} : r_q.addr + 1'b1;

        if (!cs) begin
            if (r_q.st == S_ARMED && r_q.ewen && !busy) begin
                start = 1'b1;
                prog  = (r_q.kind == K_FILL || r_q.kind == K_CLEAR) ? P_ALL : P_ONE;
            end
            r_d.st   = S_IDLE;
            r_d.oe   = 1'b0;
            r_d.dout = 1'b0;
        end else begin
            case (r_q.st)
                S_IDLE: begin
                    if (busy) begin
                        r_d.st   = S_STAT;
                        r_d.oe   = 1'b1;
                        r_d.dout = 1'b0;
                    end else begin
                        r_d.st = S_WAIT;
                    end
                end
                S_STAT: begin
                    r_d.dout = ~busy;
                    if (!busy && rise && di) begin
                        r_d.st   = S_CMD;
                        r_d.cnt  = '0;
                        r_d.oe   = 1'b0;
                        r_d.dout = 1'b0;
                    end
                end
                S_WAIT: begin
                    if (rise && di) begin
                        r_d.st  = S_CMD;
                        r_d.cnt = '0;
                    end
                end
                S_CMD: begin
                    if (rise) begin
                        r_d.cmd = cmdv;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == clen - 1'b1) begin
                            r_d.addr = cadr;
                            r_d.cnt  = '0;
                            case (opc)
                                2'b10: begin
                                    r_d.st   = S_READ;
                                    r_d.oe   = 1'b1;
                                    r_d.dout = 1'b0;
                                    r_d.cnt  = wlen;
                                end
                                2'b01: begin
                                    r_d.st   = S_DATA;
                                    r_d.kind = K_WORD;
                                end
                                2'b11: begin
                                    r_d.st   = S_ARMED;
                                    r_d.kind = K_ERASE;
                                end
                                default: begin
                                    case (sub)
                                        2'b11: begin
                                            r_d.ewen = 1'b1;
                                            r_d.st   = S_DONE;
                                        end
                                        2'b00: begin
                                            r_d.ewen = 1'b0;
                                            r_d.st   = S_DONE;
                                        end
                                        2'b10: begin
                                            r_d.st   = S_ARMED;
                                            r_d.kind = K_CLEAR;
                                        end
                                        default: begin
                                            r_d.st   = S_DATA;
                                            r_d.kind = K_FILL;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                S_DATA: begin
                    if (rise) begin
                        r_d.data = datv;
                        r_d.cnt  = r_q.cnt + 1'b1;
                        if (r_q.cnt == wlen - 1'b1) begin
                            r_d.st = S_ARMED;
                        end
                    end
                end
                S_READ: begin
                    if (rise) begin
                        r_d.dout = rword[4'(r_q.cnt - 1'b1)];
                        if (r_q.cnt == CNT_W'(1)) begin
                            r_d.addr = inc;
                            r_d.cnt  = wlen;
                        end else begin
                            r_d.cnt = r_q.cnt - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.kind <= K_WORD;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr  = r_q.addr;
    assign wdata = (r_q.kind == K_ERASE || r_q.kind == K_CLEAR) ? '1 : r_q.data;
    assign ewen  = r_q.ewen;
    assign do_o  = r_q.dout;
    assign do_oe = r_q.oe;
endmodule

// File: rtl/uw_eeprom.sv
module uw_eeprom
    import uw_pkg::*;
#(
    parameter int BUSY_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org,
    output logic do_o,
    output logic do_oe
);
    logic               busy_w;
    logic               ewen_w;
    logic               start_w;
    uw_prog_e           prog_w;
    logic [BADDR_W-1:0] addr_w;
    logic [WORD_W-1:0]  wdata_w;
    logic [WORD_W-1:0]  rword_w;

    uw_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .sk    (sk),
        .di    (di),
        .org   (org),
        .busy  (busy_w),
        .rword (rword_w),
        .addr  (addr_w),
        .prog  (prog_w),
        .wdata (wdata_w),
        .start (start_w),
        .ewen  (ewen_w),
        .do_o  (do_o),
        .do_oe (do_oe)
    );

    uw_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .prog  (prog_w),
        .org   (org),
        .waddr (addr_w),
        .wdata (wdata_w),
        .raddr (addr_w),
        .rword (rword_w)
    );

    uw_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_w),
        .busy  (busy_w)
    );
endmodule

// File: rtl/uw_eeprom_chk.sv
module uw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic do_o,
    input logic do_oe,
    input logic busy,
    input logic ewen
);
    // R10: deselect releases the output on the next clock
    a_r10_hiz_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !do_oe);

    // R9: while the self-timed cycle runs, a driven output reads low
    a_r9_busy_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && do_oe) |-> !do_o);

    // R6: a self-timed cycle begins only with programming enabled
    a_r6_launch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ewen));

    // R5: a self-timed cycle begins only on a deselected bus
    a_r5_launch_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!cs));

    // R3: the first driven bit is always a zero
    a_r3_first_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_oe) |-> !do_o);
endmodule

bind uw_eeprom uw_eeprom_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .do_o  (do_o),
    .do_oe (do_oe),
    .busy  (busy_w),
    .ewen  (ewen_w)
);

// File: tb/sim_uw_eeprom.sv
module sim_uw_eeprom;
    localparam int BUSY = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic do_o, do_oe;

    int errors = 0;
    int checks = 0;
    logic last_q;
    logic [7:0] mirror [256];

    always #4 clk = ~clk;

    uw_eeprom #(.BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
        .do_o(do_o), .do_oe(do_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (ok !== 1'b1) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int alen();
        return org ? 7 : 8;
    endfunction

    function automatic logic [7:0] ext_addr(input logic [1:0] s);
        return org ? {1'b0, s, 5'b0} : {s, 6'b0};
    endfunction

    function automatic logic [15:0] word_exp(input logic [7:0] a);
        return {mirror[{a[6:0], 1'b0}], mirror[{a[6:0], 1'b1}]};
    endfunction

    function automatic logic [15:0] pat(input int a);
        return {8'(a * 7 + 3), 8'(a) ^ 8'h5A};
    endfunction

    task automatic clk_bit(input logic b, output logic q);
        di = b;
        tick(2);
        sk = 1'b1;
        tick(4);
        q = do_o;
        sk = 1'b0;
        tick(2);
    endtask

    task automatic send_head(input logic [1:0] op, input logic [7:0] a, input int lead);
        logic q;
        cs = 1'b1;
        tick(2);
        for (int i = 0; i < lead; i++) clk_bit(1'b0, q);
        clk_bit(1'b1, q);
        clk_bit(op[1], q);
        clk_bit(op[0], q);
        for (int i = alen() - 1; i >= 0; i--) clk_bit(a[i], q);
        last_q = q;
    endtask

    task automatic send_data(input logic [15:0] d);
        logic q;
        for (int i = (org ? 15 : 7); i >= 0; i--) clk_bit(d[i], q);
    endtask

    task automatic deselect();
        cs = 1'b0;
        tick(2);
    endtask

    task automatic rd_seq(input logic [7:0] a, input int n, input string req, input int lead);
        logic q;
        logic [15:0] val, exp;
        logic [7:0] cur;
        send_head(2'b10, a, lead);
        check(do_oe === 1'b1 && last_q === 1'b0, "R3 dummy bit", {do_oe, last_q}, 2'b10);
        cur = a;
        for (int w = 0; w < n; w++) begin
            val = '0;
            for (int b = 0; b < (org ? 16 : 8); b++) begin
                clk_bit(1'b0, q);
                val = {val[14:0], q};
            end
            exp = org ? word_exp(cur) : {8'h00, mirror[cur]};
            check(val === exp, req, {8'h0, cur, val}, {8'h0, cur, exp});
            cur = org ? {1'b0, cur[6:0] + 7'd1} : cur + 8'd1;
        end
        deselect();
    endtask

    task automatic wait_ready(input string req);
        int k;
        cs = 1'b1;
        tick(3);
        check(do_oe === 1'b1 && do_o === 1'b0, "R9 busy shows 0", {do_oe, do_o}, 2'b10);
        k = 0;
        while (do_o !== 1'b1 && k < BUSY + 50) begin
            tick(1);
            k++;
        end
        check(do_o === 1'b1 && do_oe === 1'b1, req, {do_oe, do_o}, 2'b11);
        deselect();
    endtask

    task automatic expect_idle(input string req);
        cs = 1'b1;
        tick(3);
        check(do_oe === 1'b0, req, do_oe, 0);
        deselect();
    endtask

    task automatic put_word(input logic [7:0] a, input logic [15:0] d);
        send_head(2'b01, a, 0);
        send_data(d);
        deselect();
    endtask

    task automatic ext(input logic [1:0] s);
        send_head(2'b00, ext_addr(s), 0);
        deselect();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic q;
        for (int i = 0; i < 256; i++) mirror[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R11: reset state
        check(do_oe === 1'b0, "R11 output released", do_oe, 0);
        rd_seq(8'd0, 2, "R11 erased after reset", 0);

        // R6: protected after reset
        put_word(8'd5, 16'h1234);
        expect_idle("R6 write ignored when protected");
        ext(2'b10);
        expect_idle("R6 erase-all ignored when protected");
        rd_seq(8'd5, 1, "R6 word unchanged", 0);

        // R5: sweep every wide word
        ext(2'b11);
        for (int a = 0; a < 128; a++) begin
            put_word(8'(a), pat(a));
            mirror[2 * a]     = pat(a) >> 8;
            mirror[2 * a + 1] = pat(a) & 16'hFF;
            wait_ready("R9 ready after write");
        end
        // R4: sequential read across all words and wrap
        rd_seq(8'd0, 128, "R5 wide write sweep", 0);
        rd_seq(8'd126, 4, "R4 wide wrap", 0);

        // R1: byte view of the same cells
        org = 1'b0;
        tick(2);
        rd_seq(8'd0, 256, "R1 byte view mapping", 0);
        put_word(8'h83, 16'h00C5);
        mirror[8'h83] = 8'hC5;
        wait_ready("R9 ready after byte write");
        rd_seq(8'h82, 3, "R5 byte write single byte", 0);
        rd_seq(8'hFF, 3, "R4 byte wrap", 0);
        org = 1'b1;
        tick(2);
        rd_seq(8'h41, 1, "R1 byte seen in word", 0);

        // R7: single erase
        send_head(2'b11, 8'd10, 0);
        deselect();
        mirror[20] = 8'hFF;
        mirror[21] = 8'hFF;
        wait_ready("R9 ready after erase");
        rd_seq(8'd9, 3, "R7 erase one word", 0);

        // R9: instructions ignored while busy
        put_word(8'd20, 16'hAAAA);
        mirror[40] = 8'hAA;
        mirror[41] = 8'hAA;
        cs = 1'b1;
        tick(3);
        clk_bit(1'b1, q);
        check(q === 1'b0 && do_oe === 1'b1, "R9 start bit ignored while busy", {do_oe, q}, 2'b10);
        clk_bit(1'b1, q);
        clk_bit(1'b0, q);
        check(q === 1'b0 && do_oe === 1'b1, "R9 status held while busy", {do_oe, q}, 2'b10);
        deselect();
        wait_ready("R9 ready after busy test");
        rd_seq(8'd20, 1, "R9 write done", 0);

        // R10: aborts
        send_head(2'b01, 8'd21, 0);
        for (int i = 0; i < 5; i++) clk_bit(1'b0, q);
        deselect();
        check(do_oe === 1'b0, "R10 released on abort", do_oe, 0);
        expect_idle("R10 aborted write not launched");
        rd_seq(8'd21, 1, "R10 word unchanged", 0);
        send_head(2'b10, 8'd3, 0);
        clk_bit(1'b0, q);
        deselect();
        check(do_oe === 1'b0, "R10 read abandoned", do_oe, 0);

        // R2: leading zeros before the start bit
        rd_seq(8'd7, 1, "R2 leading zeros ignored", 3);

        // R6: disable again
        ext(2'b00);
        put_word(8'd22, 16'h0000);
        expect_idle("R6 write ignored after disable");
        rd_seq(8'd22, 1, "R6 word kept after disable", 0);
        ext(2'b11);

        // R8: fill all, then erase all
        send_head(2'b00, ext_addr(2'b01), 0);
        send_data(16'h3C96);
        deselect();
        for (int i = 0; i < 256; i++) mirror[i] = (i % 2 == 0) ? 8'h3C : 8'h96;
        wait_ready("R9 ready after fill");
        rd_seq(8'd0, 128, "R8 fill all", 0);
        ext(2'b10);
        for (int i = 0; i < 256; i++) mirror[i] = 8'hFF;
        wait_ready("R9 ready after erase-all");
        rd_seq(8'd0, 128, "R8 erase all", 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule